// File: doc/BRIEF.md
# Lockable GPIO Port Register Block

This block is an eight-pin general-purpose I/O port controlled through a 4 KB memory-mapped register window on a simple APB-style slave bus. Software sets the direction of each pin. It reads and writes pin values through a data register, and the address of each access carries a bit mask that picks which pins the access touches. Input pins are sampled into the data register on every clock. Output pins drive the stored data bit on `pin_out`.

Each pin can raise an interrupt on a level, on one edge or on both edges. A raw status register collects the events. Software clears status bits by writing ones, and a mask register selects which events reach the single `irq` line. A set of pad-control registers only stores values for the pad ring. The alternate-function select register is guarded: each of its bits can change only while the matching bit of a commit register is 1. The commit register can only be rewritten after a key has been written to the lock register. Twelve read-only identification bytes sit at the top of the window.

Every bus access completes in its access phase with no wait states.

Top module: `pinport_ctrl`

## Requirements
- R1: Any word offset below 0x400 reads the data register ANDed with a mask taken from address bits [9:2]. Bits 31:8 read 0.
- R2: A write below 0x400 changes only the data bits that are 1 in both the address mask (bits [9:2]) and the direction register. Every other data bit keeps its value.
- R3: The direction register is at 0x400, and a 1 marks an output. On every clock edge, each input pin's data bit loads `pin_in`, so the data bit follows the pin one cycle later. Output pins ignore `pin_in`. `pin_out` equals data AND direction, so input pins drive 0.
- R4: Interrupt detection is configured per pin through three registers: level/edge at 0x404 (1 = level), both-edges at 0x408 and event polarity at 0x40C (1 = rising or high). In level mode a raw bit is set while the data bit equals its event bit. In edge mode with both-edges set, either transition sets the raw bit. Otherwise only the transition named by the event bit sets it. A raw bit is set two cycles after the pin changes.
- R5: Writing ones to 0x41C clears the matching raw status bits. A detection in the same cycle takes priority over the clear.
- R6: The mask register is at 0x410. Raw status reads at 0x414, and masked status at 0x418 reads raw AND mask. `irq` is 1 exactly when any masked status bit is 1.
- R7: Writing 0x0ACCE551 to 0x520 unlocks the block, and any other value locks it. Reading 0x520 returns 1 while locked and 0 while unlocked. Reset leaves the block locked.
- R8: The commit register is at 0x524. Writes change it only while the block is unlocked. It resets to 0xFF.
- R9: A write to the alternate-function register at 0x420 updates only the bits whose commit bit is 1.
- R10: The eight words at 0x500 to 0x51C are plain 8-bit read/write storage. So are 0x400 to 0x410 and 0x420 when unguarded.
- R11: Word offsets 0xFD0 to 0xFFC read the bytes 00,00,00,00,61,00,18,01,0D,F0,05,B1 in that order.
- R12: Unmapped offsets read 0 and ignore writes. After reset, every register reads 0 except the lock register (1) and the commit register (0xFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, valid in the access phase |
| pin_in | input | NPINS | External pin levels |
| pin_out | output | NPINS | Driven pin levels (data AND direction) |
| irq | output | 1 | OR of masked interrupt status |

## Verification
The bench uses the default build: eight pins and a 32-bit data bus. With eight pins, every address-mask pattern in bits [9:2] is reachable, and all eight pad-control words exist.

The data section changes direction, pin levels, write masks and read masks at random. That covers every mix of pins that are written, held and sampled.

The directed part walks each detection mode on its own pin. It also covers the set-over-clear priority, the full lock/commit sequence, both a correct and a wrong key, and the whole ID range.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
  localparam logic [11:0] OFS_DIR    = 12'h400;
  localparam logic [11:0] OFS_SENSE  = 12'h404;
  localparam logic [11:0] OFS_BOTH   = 12'h408;
  localparam logic [11:0] OFS_EVT    = 12'h40C;
  localparam logic [11:0] OFS_IMASK  = 12'h410;
  localparam logic [11:0] OFS_RAW    = 12'h414;
  localparam logic [11:0] OFS_MIS    = 12'h418;
  localparam logic [11:0] OFS_ICLR   = 12'h41C;
  localparam logic [11:0] OFS_ALT    = 12'h420;
  localparam logic [11:0] OFS_PAD0   = 12'h500;
  localparam logic [11:0] OFS_LOCK   = 12'h520;
  localparam logic [11:0] OFS_COMMIT = 12'h524;
  localparam logic [9:0]  ID_WBASE   = 10'h3F4;
  localparam int unsigned PAD_REGS   = 8;
  localparam int unsigned ID_BYTES   = 12;
  localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h61;
      4'd6:    b = 8'h18;
      4'd7:    b = 8'h01;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/pinport_cfg.sv
module pinport_cfg
  import pinport_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned DW    = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [11:0]                        waddr,
  input  logic [DW-1:0]                      wdata,
  output logic [NPINS-1:0]                   dir_o,
  output logic [NPINS-1:0]                   sense_o,
  output logic [NPINS-1:0]                   both_o,
  output logic [NPINS-1:0]                   evt_o,
  output logic [NPINS-1:0]                   imask_o,
  output logic [NPINS-1:0]                   alt_o,
  output logic [PAD_REGS-1:0][NPINS-1:0]     pad_o,
  output logic                               locked_o,
  output logic [NPINS-1:0]                   commit_o
);
  logic [NPINS-1:0] wbyte;
  logic [NPINS-1:0] dir_q, dir_d, sense_q, sense_d, both_q, both_d;
  logic [NPINS-1:0] evt_q, evt_d, imask_q, imask_d, alt_q, alt_d;
  logic [NPINS-1:0] commit_q, commit_d;
  logic             locked_q, locked_d;
  logic             hit_lock, hit_commit, hit_alt;

  assign wbyte      = wdata[NPINS-1:0];
  assign hit_lock   = wr_en && (waddr == OFS_LOCK);
  assign hit_commit = wr_en && (waddr == OFS_COMMIT);
  assign hit_alt    = wr_en && (waddr == OFS_ALT);

  always_comb begin
    dir_d    = dir_q;
    sense_d  = sense_q;
    both_d   = both_q;
    evt_d    = evt_q;
    imask_d  = imask_q;
    alt_d    = alt_q;
    commit_d = commit_q;
    locked_d = locked_q;
    if (wr_en) begin
      case (waddr)
        OFS_DIR:   dir_d   = wbyte;
        OFS_SENSE: sense_d = wbyte;
        OFS_BOTH:  both_d  = wbyte;
        OFS_EVT:   evt_d   = wbyte;
        OFS_IMASK: imask_d = wbyte;
        default: ;
      endcase
    end
    if (hit_alt)
      alt_d = (alt_q & ~commit_q) | (wbyte & commit_q);
    if (hit_lock)
      locked_d = (wdata != DW'(UNLOCK_KEY));
    if (hit_commit && !locked_q)
      commit_d = wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      sense_q  <= '0;
      both_q   <= '0;
      evt_q    <= '0;
      imask_q  <= '0;
      alt_q    <= '0;
      commit_q <= '1;
      locked_q <= 1'b1;
    end else begin
      dir_q    <= dir_d;
      sense_q  <= sense_d;
      both_q   <= both_d;
      evt_q    <= evt_d;
      imask_q  <= imask_d;
      alt_q    <= alt_d;
      commit_q <= commit_d;
      locked_q <= locked_d;
    end
  end

  for (genvar k = 0; k < PAD_REGS; k++) begin : g_pad
    logic             hit;
    logic [NPINS-1:0] q, d;
    assign hit = wr_en && (waddr == OFS_PAD0 + 12'(4 * k));
    always_comb d = hit ? wbyte : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign pad_o[k] = q;
  end

  assign dir_o    = dir_q;
  assign sense_o  = sense_q;
  assign both_o   = both_q;
  assign evt_o    = evt_q;
  assign imask_o  = imask_q;
  assign alt_o    = alt_q;
  assign commit_o = commit_q;
  assign locked_o = locked_q;

  // R8
  commit_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(commit_q));
  // R7
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lock && wdata == DW'(UNLOCK_KEY)) |=> !locked_q);
  // R7
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lock && wdata != DW'(UNLOCK_KEY)) |=> locked_q);
  // R9
  alt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0));
endmodule

// File: rtl/pinport_data.sv
module pinport_data #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] data_o,
  output logic [NPINS-1:0] pin_out
);
  logic [NPINS-1:0] data_q, data_d, sampled, wmask;

  assign wmask = mask_i & dir_i;

  always_comb begin
    sampled = (data_q & dir_i) | (pin_in & ~dir_i);
    data_d  = wr_en ? ((sampled & ~wmask) | (wdata_i & wmask)) : sampled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o  = data_q;
  assign pin_out = data_q & dir_i;

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((data_q & $past(dir_i)) == ($past(data_q) & $past(dir_i))));
  // R3
  in_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q & ~$past(dir_i)) == ($past(pin_in) & ~$past(dir_i))));
endmodule

// File: rtl/pinport_irq.sv
module pinport_irq #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] data_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] imask_i,
  input  logic             clr_en_i,
  input  logic [NPINS-1:0] clr_val_i,
  output logic [NPINS-1:0] raw_o,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_o
);
  logic [NPINS-1:0] prev_q, raw_q, raw_d, hit, clr;

  for (genvar i = 0; i < NPINS; i++) begin : g_det
    logic rise, fall;
    assign rise = data_i[i] & ~prev_q[i];
    assign fall = ~data_i[i] & prev_q[i];
    always_comb begin
      if (sense_i[i])     hit[i] = (data_i[i] == evt_i[i]);
      else if (both_i[i]) hit[i] = rise | fall;
      else if (evt_i[i])  hit[i] = rise;
      else                hit[i] = fall;
    end
  end

  assign clr = clr_en_i ? clr_val_i : '0;

  always_comb raw_d = (raw_q & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= data_i;
      raw_q  <= raw_d;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & imask_i;
  assign irq_o    = |masked_o;

  // R4
  no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == '0 && data_i == prev_q) |=> ((raw_q & ~$past(raw_q)) == '0));
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && sense_i == '0 && data_i == prev_q) |=> ((raw_q & $past(clr_val_i)) == '0));
  // R6
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_i == '0) |-> !irq_o);
endmodule

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
  import pinport_pkg::*;
#(
  parameter int unsigned NPINS = 8,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [11:0]      paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic             irq
);
  localparam int unsigned MSB = NPINS + 1;

  logic                           wr_en, data_wr, clr_en;
  logic [NPINS-1:0]               amask;
  logic [NPINS-1:0]               dir, sense, both, evt, imask, alt, commit;
  logic [NPINS-1:0]               data, raw, masked;
  logic [PAD_REGS-1:0][NPINS-1:0] pad;
  logic                           locked;
  logic [9:0]                     widx;

  assign wr_en   = psel && penable && pwrite;
  assign data_wr = wr_en && (paddr < OFS_DIR);
  assign clr_en  = wr_en && (paddr == OFS_ICLR);
  assign amask   = paddr[MSB:2];
  assign widx    = paddr[11:2] - ID_WBASE;

  pinport_cfg #(.NPINS(NPINS), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(paddr), .wdata(pwdata),
    .dir_o(dir), .sense_o(sense), .both_o(both), .evt_o(evt), .imask_o(imask),
    .alt_o(alt), .pad_o(pad), .locked_o(locked), .commit_o(commit)
  );

  pinport_data #(.NPINS(NPINS)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .mask_i(amask),
    .wdata_i(pwdata[NPINS-1:0]), .dir_i(dir), .pin_in(pin_in),
    .data_o(data), .pin_out(pin_out)
  );

  pinport_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .data_i(data), .sense_i(sense), .both_i(both),
    .evt_i(evt), .imask_i(imask), .clr_en_i(clr_en),
    .clr_val_i(pwdata[NPINS-1:0]), .raw_o(raw), .masked_o(masked), .irq_o(irq)
  );

  always_comb begin
    prdata = '0;
    if (paddr < OFS_DIR) begin
      prdata[NPINS-1:0] = data & amask;
    end else if (paddr[1:0] == 2'b00 && paddr[11:5] == OFS_PAD0[11:5]) begin
      prdata[NPINS-1:0] = pad[paddr[4:2]];
    end else if (paddr[1:0] == 2'b00 && widx < 10'(ID_BYTES) && paddr[11:2] >= ID_WBASE) begin
      prdata[7:0] = id_byte(widx[3:0]);
    end else begin
      case (paddr)
        OFS_DIR:    prdata[NPINS-1:0] = dir;
        OFS_SENSE:  prdata[NPINS-1:0] = sense;
        OFS_BOTH:   prdata[NPINS-1:0] = both;
        OFS_EVT:    prdata[NPINS-1:0] = evt;
        OFS_IMASK:  prdata[NPINS-1:0] = imask;
        OFS_RAW:    prdata[NPINS-1:0] = raw;
        OFS_MIS:    prdata[NPINS-1:0] = masked;
        OFS_ALT:    prdata[NPINS-1:0] = alt;
        OFS_LOCK:   prdata[0]         = locked;
        OFS_COMMIT: prdata[NPINS-1:0] = commit;
        default: ;
      endcase
    end
  end

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw != '0));
  // R3
  pin_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~dir) == '0);
endmodule

// File: tb/pinport_ctrl_tb.sv
module pinport_ctrl_tb;
  localparam int NP = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [11:0]   paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata;
  logic [NP-1:0] pin_in, pin_out;
  logic          irq;

  int nvec = 0;
  int nerr = 0;

  logic [7:0] m_dir, m_data, m_pin;

  always #5 clk = ~clk;

  pinport_ctrl #(.NPINS(NP), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 v = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk);
    pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] id_exp(input int i);
    logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                           8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [7:0] data_after_write(input logic [7:0] d, input logic [7:0] msk,
                                                  input logic [7:0] dr, input logic [7:0] wd);
    return (d & ~(msk & dr)) | (wd & msk & dr);
  endfunction

  initial begin
    #(10 * 150000);
    nerr++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h1A2B3C4D);
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pin_in = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R12, R7, R8)
    rchk("R12 reset dir", 12'h400, 0);
    rchk("R12 reset alt", 12'h420, 0);
    rchk("R12 reset raw", 12'h414, 0);
    rchk("R7 reset locked", 12'h520, 1);
    rchk("R8 reset commit", 12'h524, 32'hFF);
    chk("R12 reset irq", {31'b0, irq}, 0);

    // R11 id bytes
    for (int i = 0; i < 12; i++)
      rchk("R11 id", 12'hFD0 + 12'(4 * i), {24'b0, id_exp(i)});

    // R10 pad storage and plain config registers
    for (int k = 0; k < 8; k++) wr(12'h500 + 12'(4 * k), 32'hFFFF_FF00 | 32'(8'h11 * (k + 1)));
    for (int k = 0; k < 8; k++) rchk("R10 pad", 12'h500 + 12'(4 * k), 32'(8'h11 * (k + 1)));
    wr(12'h40C, 32'h0000_015A);
    rchk("R10 evt storage", 12'h40C, 32'h5A);
    wr(12'h40C, 0);

    // R12 unmapped
    wr(12'h600, 32'hFFFF_FFFF);
    rchk("R12 unmapped read", 12'h600, 0);
    rchk("R12 unmapped write no effect dir", 12'h400, 0);
    rchk("R12 unmapped write no effect commit", 12'h524, 32'hFF);

    // Lock / commit / alternate function (R7, R8, R9)
    wr(12'h524, 32'h0F);
    rchk("R8 commit write while locked", 12'h524, 32'hFF);
    wr(12'h420, 32'hAA);
    rchk("R9 alt all committed", 12'h420, 32'hAA);
    wr(12'h520, 32'h0ACC_E551);
    rchk("R7 unlocked by key", 12'h520, 0);
    wr(12'h524, 32'h0F);
    rchk("R8 commit write while unlocked", 12'h524, 32'h0F);
    wr(12'h520, 32'h0ACC_E550);
    rchk("R7 wrong key locks", 12'h520, 1);
    wr(12'h524, 32'h00);
    rchk("R8 commit held after relock", 12'h524, 32'h0F);
    wr(12'h420, 32'h55);
    rchk("R9 alt partial", 12'h420, 32'hA5);

    // Random data access (R1, R2, R3)
    m_dir = 0; m_data = 0; m_pin = 0;
    for (int it = 0; it < 300; it++) begin
      logic [7:0] msk, wd, rm;
      if ($urandom % 4 == 0) begin
        m_dir = 8'($urandom);
        wr(12'h400, {24'hABCDEF, m_dir});
        m_data = (m_data & m_dir) | (m_pin & ~m_dir);
      end
      if ($urandom % 3 == 0) begin
        m_pin = 8'($urandom);
        @(negedge clk) pin_in = m_pin;
        @(negedge clk);
        m_data = (m_data & m_dir) | (m_pin & ~m_dir);
      end
      msk = (it == 0) ? 8'hFF : (it == 1) ? 8'h00 : 8'($urandom);
      wd = 8'($urandom);
      wr({2'b00, msk, 2'b00}, {24'hFFFFFF, wd});
      m_data = data_after_write(m_data, msk, m_dir, wd);
      m_data = (m_data & m_dir) | (m_pin & ~m_dir);
      rm = (it == 2) ? 8'h00 : 8'($urandom);
      rchk("R1 R2 masked data read", {2'b00, rm, 2'b01}, {24'b0, m_data & rm});
      chk("R3 pin_out", {24'b0, pin_out}, {24'b0, m_data & m_dir});
    end

    // Interrupts (R4, R5, R6)
    wr(12'h400, 0);
    wr(12'h404, 0);
    wr(12'h408, 0);
    wr(12'h40C, 32'hFF);
    wr(12'h410, 0);
    set_pins(8'h00);
    wr(12'h41C, 32'hFF);
    rchk("R5 clear all", 12'h414, 0);
    set_pins(8'h01);
    rchk("R4 rising edge", 12'h414, 32'h01);
    chk("R6 irq masked off", {31'b0, irq}, 0);
    rchk("R6 masked status none", 12'h418, 0);
    wr(12'h410, 32'h01);
    rchk("R6 masked status", 12'h418, 32'h01);
    chk("R6 irq on", {31'b0, irq}, 1);
    wr(12'h410, 32'h02);
    chk("R6 irq other mask", {31'b0, irq}, 0);
    wr(12'h41C, 32'h01);
    set_pins(8'h00);
    rchk("R4 falling ignored in rising mode", 12'h414, 0);
    set_pins(8'h01);
    wr(12'h41C, 32'hFF);
    wr(12'h408, 32'h04);
    set_pins(8'h05);
    rchk("R4 both edges rise", 12'h414, 32'h04);
    wr(12'h41C, 32'hFF);
    set_pins(8'h01);
    rchk("R4 both edges fall", 12'h414, 32'h04);
    wr(12'h41C, 32'hFF);
    wr(12'h40C, 32'hF7);
    set_pins(8'h09);
    rchk("R4 falling mode ignores rise", 12'h414, 0);
    set_pins(8'h01);
    rchk("R4 falling mode fall", 12'h414, 32'h08);
    wr(12'h41C, 32'hFF);
    wr(12'h404, 32'h10);
    rchk("R4 level inactive", 12'h414, 0);
    set_pins(8'h11);
    rchk("R4 level active", 12'h414, 32'h10);
    wr(12'h41C, 32'h10);
    rchk("R5 level set wins over clear", 12'h414, 32'h10);
    wr(12'h404, 0);
    wr(12'h41C, 32'h10);
    rchk("R5 clear after level removed", 12'h414, 0);

    summary();
  end
endmodule